// File: doc/BRIEF.md
# Quadrature Direct Digital Synthesizer with Phase Dither

This block generates a cosine and a sine of the same phase, one sample for each clock on which the enable input is high. A wide phase accumulator adds an integer tuning word once per sample. The output frequency is the sample rate times the tuning word divided by 2^ACC_W, so the frequency step is the sample rate divided by 2^ACC_W. The accumulator value is rounded to a shorter table address. That address reads a cosine table, and the same table read a quarter period earlier gives the sine. The pair can then form a complex exponential, for example in a frequency-translation mixer.

A dither input is also provided. When it is high, a small pseudo-random offset from a 16-bit LFSR is added to the phase just before the rounding step. This spreads the periodic truncation error into a noise floor. The stored accumulator never sees the offset, so the average frequency stays exact. Each output sample has a fixed two-cycle latency.

Top module: `dds_quad_synth`

## Requirements
- R1: On every clock with `en` high, the accumulator takes the value accumulator + `tune_word` modulo 2^ACC_W. With `en` low it keeps its value. Each sample uses the accumulator value from before that enable's addition, so the first sample after reset uses phase 0.
- R2: The table address is the phase value p presented to the quantizer, rounded to nearest: (p + 2^(SH-1)) >> SH, with SH = ACC_W-ADDR_W. A result of 2^ADDR_W wraps to address 0.
- R3: `cos_o` is the two's-complement value round(A*cos(2*pi*addr/2^ADDR_W)), where A = 2^(SAMP_W-1)-1 and the rounding is to nearest with halves away from zero.
- R4: `sin_o` is the table entry at address (addr - 2^(ADDR_W-2)) mod 2^ADDR_W, which is A*sin of the same phase.
- R5: While `valid_o` is high, neither output ever takes the value -2^(SAMP_W-1).
- R6: If `en` is high at rising edge t, then `valid_o` is high after edge t+1 and shows that sample. Otherwise `valid_o` is low. While `valid_o` is low, both outputs hold their last values.
- R7: With `dith_en` high, the quantizer sees p = accumulator + d modulo 2^ACC_W. Here d is the signed value of LFSR bits [DITH_W-1:0] times 2^(SH-3-(DITH_W-1)). With `dith_en` low, d is 0.
- R8: The LFSR is 16 bits wide and loads 16'hACE1 on reset. On every enable, whatever the state of `dith_en`, it shifts left and inserts bit15^bit13^bit12^bit10 at bit 0. The state used for a sample is the state from before that shift, and the state is never zero.
- R9: Dither never changes the stored accumulator. After a dithered run, samples with `dith_en` low equal those of an accumulator that was never dithered.
- R10: A synchronous active-high `rst` clears the accumulator, `valid_o`, `cos_o` and `sin_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Produce one sample on this clock |
| tune_word | input | ACC_W | Phase increment per sample |
| dith_en | input | 1 | Add LFSR dither before the rounding step |
| cos_o | output | SAMP_W | Signed cosine sample |
| sin_o | output | SAMP_W | Signed sine sample |
| valid_o | output | 1 | Samples on cos_o/sin_o are new this cycle |

## Verification
A tuning word of exactly a quarter turn gives the four exact corner values, which tells the sine offset apart from the cosine. A slow word and a large, nearly negative word test accumulator wrap and reverse rotation. Words close to half an address step and one half-step below full scale separate rounding from truncation and test the wrap of the top address to 0. Gapped enables check latency and output hold, and dithered runs with dither switched off and on again show that the LFSR advances on every enable and that the accumulator stays clean.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam real TWO_PI = 6.283185307179586476;

  function automatic int cos_code(input int idx, input int addr_w, input int samp_w);
    real amp;
    amp = real'((1 << (samp_w - 1)) - 1);
    return int'(amp * $cos(TWO_PI * real'(idx) / real'(1 << addr_w)));
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] phase_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_q + step;
  end

  assign phase_o = acc_q;

  assert_acc_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_q));
  assert_acc_step_R1: assert property (@(posedge clk) disable iff (rst)
    en |=> (acc_q - $past(acc_q)) == $past(step));
endmodule

// File: rtl/dds_dither_lfsr.sv
module dds_dither_lfsr #(
  parameter int          DITH_W = 4,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [DITH_W-1:0] slice_o
);
  logic [15:0] st_q;
  logic        fb;

  assign fb = st_q[15] ^ st_q[13] ^ st_q[12] ^ st_q[10];

  always_ff @(posedge clk) begin
    if (rst)     st_q <= SEED;
    else if (en) st_q <= {st_q[14:0], fb};
  end

  assign slice_o = st_q[DITH_W-1:0];

  assert_lfsr_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
    st_q != '0);
  assert_lfsr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(st_q));
endmodule

// File: rtl/dds_phase_quant.sv
module dds_phase_quant #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 10,
  parameter int DITH_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ACC_W-1:0]  phase,
  input  logic [DITH_W-1:0] dith,
  input  logic              dith_en,
  output logic [ADDR_W-1:0] addr_o,
  output logic              vld_o
);
  localparam int SH  = ACC_W - ADDR_W;
  localparam int DSH = SH - 3 - (DITH_W - 1);
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (SH - 1);

  logic signed [ACC_W-1:0] dext;
  logic        [ACC_W-1:0] offs;
  logic        [ACC_W-1:0] qin;
  logic        [ACC_W-1:0] rnd;

  generate
    if (DSH >= 0) begin : g_up
      assign dext = ACC_W'($signed(dith)) <<< DSH;
    end else begin : g_down
      assign dext = ACC_W'($signed(dith)) >>> (-DSH);
    end
  endgenerate

  assign offs = dith_en ? dext : '0;
  assign qin  = phase + offs;
  assign rnd  = qin + HALF;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
    end else begin
      vld_o <= en;
      if (en) addr_o <= rnd[ACC_W-1:SH];
    end
  end

  assert_stage_follows_en_R6: assert property (@(posedge clk) disable iff (rst)
    en |=> vld_o);
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(addr_o));
endmodule

// File: rtl/dds_quad_rom.sv
module dds_quad_rom #(
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [SAMP_W-1:0] cos_o,
  output logic signed [SAMP_W-1:0] sin_o
);
  import dds_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] QTR = ADDR_W'(DEPTH / 4);

  logic signed [SAMP_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] sin_addr;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = SAMP_W'(cos_code(i, ADDR_W, SAMP_W));
  end

  assign sin_addr = addr - QTR;

  always_ff @(posedge clk) begin
    if (rst) begin
      cos_o <= '0;
      sin_o <= '0;
    end else if (rd_en) begin
      cos_o <= mem[addr];
      sin_o <= mem[sin_addr];
    end
  end
endmodule

// File: rtl/dds_quad_synth.sv
module dds_quad_synth #(
  parameter int          ACC_W     = 32,
  parameter int          ADDR_W    = 10,
  parameter int          SAMP_W    = 14,
  parameter int          DITH_W    = 4,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic [ACC_W-1:0]         tune_word,
  input  logic                     dith_en,
  output logic signed [SAMP_W-1:0] cos_o,
  output logic signed [SAMP_W-1:0] sin_o,
  output logic                     valid_o
);
  localparam logic signed [SAMP_W-1:0] MOST_NEG = {1'b1, {(SAMP_W-1){1'b0}}};

  logic [ACC_W-1:0]  phase;
  logic [DITH_W-1:0] dith;
  logic [ADDR_W-1:0] addr_q;
  logic              vld_q;

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .en(en), .step(tune_word), .phase_o(phase));

  dds_dither_lfsr #(.DITH_W(DITH_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .en(en), .slice_o(dith));

  dds_phase_quant #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .DITH_W(DITH_W)) u_quant (
    .clk(clk), .rst(rst), .en(en), .phase(phase), .dith(dith),
    .dith_en(dith_en), .addr_o(addr_q), .vld_o(vld_q));

  dds_quad_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_rom (
    .clk(clk), .rst(rst), .rd_en(vld_q), .addr(addr_q),
    .cos_o(cos_o), .sin_o(sin_o));

  always_ff @(posedge clk) begin
    if (rst) valid_o <= 1'b0;
    else     valid_o <= vld_q;
  end

  assert_valid_rise_R6: assert property (@(posedge clk) disable iff (rst)
    vld_q |=> valid_o);
  assert_valid_low_R6: assert property (@(posedge clk) disable iff (rst)
    !vld_q |=> !valid_o);
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !vld_q |=> ($stable(cos_o) && $stable(sin_o)));
  assert_no_most_neg_R5: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (cos_o != MOST_NEG && sin_o != MOST_NEG));
endmodule

// File: tb/dds_quad_synth_bench.sv
module dds_quad_synth_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W  = 32;
  localparam int ADDR_W = 10;
  localparam int SAMP_W = 14;
  localparam int DITH_W = 4;
  localparam int N      = 1 << ADDR_W;
  localparam int SH     = ACC_W - ADDR_W;
  localparam int DSH    = SH - 3 - (DITH_W - 1);
  localparam logic [15:0] SEED = 16'hACE1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic dith_en = 1'b0;
  logic [ACC_W-1:0] tune_word = '0;
  logic signed [SAMP_W-1:0] cos_o, sin_o;
  logic valid_o;

  int checks = 0;
  int failures = 0;
  string tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_quad_synth u_dds_quad_synth (
    .clk(clk), .rst(rst), .en(en), .tune_word(tune_word), .dith_en(dith_en),
    .cos_o(cos_o), .sin_o(sin_o), .valid_o(valid_o));

  function automatic int exp_cos(input longint a);
    real amp;
    amp = real'((1 << (SAMP_W - 1)) - 1);
    return int'(amp * $cos(6.283185307179586476 * real'(a) / real'(N)));
  endfunction

  // behavioural reference model
  logic [ACC_W-1:0] acc_m;
  logic [15:0] lfsr_m;
  bit p1v, p2v;
  int p1c, p1s, hold_c, hold_s;

  always @(posedge clk) begin
    if (rst) begin
      acc_m = '0; lfsr_m = SEED; p1v = 0; p2v = 0;
      p1c = 0; p1s = 0; hold_c = 0; hold_s = 0;
    end else begin
      p2v = p1v;
      if (p1v) begin hold_c = p1c; hold_s = p1s; end
      if (en) begin
        logic [ACC_W-1:0] q;
        longint dv;
        longint ad;
        logic [DITH_W-1:0] sl;
        sl = lfsr_m[DITH_W-1:0];
        dv = dith_en ? (longint'($signed(sl)) * (longint'(1) << DSH)) : 0;
        q  = acc_m + ACC_W'(dv);
        ad = ((longint'(q) + (longint'(1) << (SH - 1))) >> SH) % N;
        p1c = exp_cos(ad);
        p1s = exp_cos((ad - N/4 + N) % N);
        p1v = 1;
        acc_m = acc_m + tune_word;
        lfsr_m = {lfsr_m[14:0], lfsr_m[15]^lfsr_m[13]^lfsr_m[12]^lfsr_m[10]};
      end else p1v = 0;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (valid_o !== p2v) begin
        failures++;
        $display("FAIL R6 (%s) valid_o actual=%0b expected=%0b", tag, valid_o, p2v);
      end
      checks++;
      if (int'(cos_o) != hold_c) begin
        failures++;
        $display("FAIL R3 (%s) cos_o actual=%0d expected=%0d", tag, cos_o, hold_c);
      end
      checks++;
      if (int'(sin_o) != hold_s) begin
        failures++;
        $display("FAIL R4 (%s) sin_o actual=%0d expected=%0d", tag, sin_o, hold_s);
      end
      if (valid_o) begin
        checks++;
        if (int'(cos_o) == -(1 << (SAMP_W-1)) || int'(sin_o) == -(1 << (SAMP_W-1))) begin
          failures++;
          $display("FAIL R5 (%s) output at most negative code actual=%0d/%0d expected=above %0d",
                   tag, cos_o, sin_o, -(1 << (SAMP_W-1)));
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    checks++;
    if (valid_o !== 1'b0 || cos_o !== '0 || sin_o !== '0) begin
      failures++;
      $display("FAIL R10 reset state actual=%0b/%0d/%0d expected=0/0/0", valid_o, cos_o, sin_o);
    end
  endtask

  task automatic run(input int n, input logic [ACC_W-1:0] w, input bit d, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tune_word = w; dith_en = d; en = 1'b1;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); en = 1'b0;
      end
    end
    @(negedge clk); en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tag = "R10";
    do_reset();
    tag = "R1 R3 R4 quarter turn";   run(8, 32'h4000_0000, 0, 0);
    tag = "R1 slow word";            run(300, 32'd3_000_000, 0, 0);
    tag = "R2 below half step";      run(20, 32'h001F_FFFF, 0, 0);
    tag = "R2 top wrap to 0";        run(12, 32'hFFE0_0000, 0, 0);
    tag = "R6 gapped enable";        run(40, 32'd123456789, 0, 3);
    tag = "R7 R8 dither";            run(400, 32'h0ACE_5001, 1, 0);
    tag = "R7 dither at zero word";  run(60, 32'h0000_0000, 1, 1);
    tag = "R9 dither off again";     run(200, 32'h0ACE_5001, 0, 0);
    tag = "R8 advance without dither"; run(50, 32'h0123_4567, 0, 0);
    tag = "R8 dither resumed";       run(100, 32'h0123_4567, 1, 2);
    tag = "R1 large word wrap";      run(200, 32'hFFFF_0001, 0, 0);
    tag = "R10 mid-run reset";
    @(negedge clk); en = 1'b1;
    do_reset();
    tag = "R1 R3 after reset";       run(30, 32'h2000_0000, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule